// File: doc/BRIEF.md
# Isochronous Receive Context Dispatcher

This block sits between an isochronous receive FIFO and a host write path. Whenever the FIFO presents a word while the dispatcher is idle, that word is taken at once as a packet header. Its channel and tag fields are compared in parallel against eight receive contexts. Each context is either tied to one channel or set to accept any channel whose bit is set in a 64-bit channel mask.

When a context accepts the packet, the block raises a bus request. It waits for the grant and then for a descriptor response that carries the host base address. Only after that does it move the payload out of the FIFO as write beats to consecutive word addresses. A one-cycle done pulse carrying the context index marks the end of the packet. A packet that no context accepts is popped from the FIFO without any bus activity, and a discard counter steps by one.

Top module: `iso_rx_dispatch`

## Requirements
- R1: After reset, fifo_pop, bus_req, wr_valid and done_valid are low and discard_count is zero.
- R2: While idle, the first FIFO word is popped in the same cycle that fifo_empty is low. That word is the header: byte length in bits 31:16, tag in bits 15:14, channel in bits 13:8. The payload that follows is ceil(length/4) words.
- R3: A single-channel context matches when it is enabled, its channel equals the header channel, and its tag-mask bit indexed by the header tag value is set.
- R4: A context in multichannel mode ignores its channel field. It matches when its channel-mask bit indexed by the header channel is set, with the same enable and tag rules as R3.
- R5: A context whose tag-mask bit for the header tag is clear does not accept the packet.
- R6: A disabled context never accepts a packet.
- R7: When several contexts match, the lowest-numbered one receives the packet.
- R8: On a match, bus_req rises the cycle after the header pop and stays high until the packet ends. No payload word is popped before desc_valid has been seen following bus_gnt.
- R9: The payload words are issued in FIFO order as wr_data. The first goes to wr_addr equal to desc_base, and each later beat goes to the previous address plus one. Beats stall while the FIFO is empty.
- R10: done_valid pulses once per accepted packet with done_ctx set to the winning index. The pulse falls in the same cycle as the last write beat.
- R11: A packet no context accepts has all its payload words popped with no bus_req and no write beat. discard_count then increases by one, visible on the cycle after the last pop.
- R12: A zero-length packet ends without payload. If it is accepted, done_valid pulses in the desc_valid cycle. If it is not accepted, discard_count steps on the cycle after the header pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | Receive FIFO has no word |
| fifo_rdata | input | 32 | Word at the FIFO head (show-ahead) |
| fifo_pop | output | 1 | Consume the head word this cycle |
| ctx_enable | input | NUM_CTX | Per-context enable |
| ctx_multi | input | NUM_CTX | Per-context multichannel mode |
| ctx_channel | input | NUM_CTX*6 | Per-context channel, context i in bits 6i+5:6i |
| ctx_chan_mask | input | NUM_CTX*64 | Per-context channel mask, context i in bits 64i+63:64i |
| ctx_tag_mask | input | NUM_CTX*4 | Per-context accepted tags, context i in bits 4i+3:4i |
| bus_req | output | 1 | Bus ownership request, held for the whole transfer |
| bus_gnt | input | 1 | Bus grant pulse |
| desc_valid | input | 1 | Descriptor response valid |
| desc_base | input | ADDR_W | Host word base address from the descriptor |
| wr_valid | output | 1 | Host write beat valid |
| wr_addr | output | ADDR_W | Host word address of the beat |
| wr_data | output | 32 | Payload word of the beat |
| done_valid | output | 1 | Packet delivered |
| done_ctx | output | $clog2(NUM_CTX) | Context that took the packet |
| discard_count | output | CNT_W | Count of dropped packets |

## Verification
The last payload write beat and the done pulse must fall in the same cycle, so the end of a transfer and its completion report cannot drift apart. The bench provokes this with one-word and multi-word packets, and with a packet whose payload arrives with a gap in the FIFO. The gap keeps the final beat late. At every falling edge where done_valid is high, the bench records whether wr_valid is also high, and it requires this for every packet with payload. For zero-length packets it instead requires the pulse to come without a beat.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  localparam int WORD_W   = 32;
  localparam int CHAN_W   = 6;
  localparam int TAG_W    = 2;
  localparam int LEN_W    = 16;
  localparam int NUM_CHAN = 1 << CHAN_W;
  localparam int NUM_TAG  = 1 << TAG_W;
  localparam int WORDS_W  = LEN_W - 1;
  localparam int LEN_LSB  = 16;
  localparam int TAG_LSB  = 14;
  localparam int CHAN_LSB = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_DESC,
    ST_COPY,
    ST_DRAIN
  } seq_state_e;

  function automatic logic [WORDS_W-1:0] payload_words(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] padded;
    padded = {1'b0, len} + (LEN_W+1)'(3);
    return WORDS_W'(padded >> 2);
  endfunction
endpackage

// File: rtl/iso_rx_ctx_match.sv
module iso_rx_ctx_match
  import iso_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                multi,
  input  logic [CHAN_W-1:0]   cfg_chan,
  input  logic [NUM_CHAN-1:0] chan_mask,
  input  logic [NUM_TAG-1:0]  tag_mask,
  input  logic [CHAN_W-1:0]   pkt_chan,
  input  logic [TAG_W-1:0]    pkt_tag,
  output logic                hit
);
  logic chan_ok;
  logic tag_ok;

  always_comb begin
    chan_ok = multi ? chan_mask[pkt_chan] : (cfg_chan == pkt_chan);
    tag_ok  = tag_mask[pkt_tag];
    hit     = enable & chan_ok & tag_ok;
  end

  // R6: a context that is switched off stays silent
  a_r6_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !hit);
endmodule

// File: rtl/iso_rx_prio.sv
module iso_rx_prio #(
  parameter int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     hit,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
    any   = |hit;
    grant = hit & (~hit + N'(1));
  end

  // R7: exactly one winner whenever any context matches
  a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((|hit) == (|grant)));
  a_r7_grant_is_index: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]);
endmodule

// File: rtl/iso_rx_seq.sv
module iso_rx_seq
  import iso_rx_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_pop,
  input  logic              hit_any,
  input  logic [IDX_W-1:0]  hit_idx,
  output logic              bus_req,
  input  logic              bus_gnt,
  input  logic              desc_valid,
  input  logic [ADDR_W-1:0] desc_base,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              done_valid,
  output logic [IDX_W-1:0]  done_ctx,
  output logic [CNT_W-1:0]  discard_count
);
  seq_state_e          state_q, state_d;
  logic [WORDS_W-1:0]  rem_q, rem_d;
  logic [IDX_W-1:0]    ctx_q, ctx_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [CNT_W-1:0]    disc_q, disc_d;
  logic [WORDS_W-1:0]  hdr_words;
  logic                rem_en, ctx_en, addr_en, disc_en;

  assign hdr_words = payload_words(fifo_rdata[LEN_LSB +: LEN_W]);

  always_comb begin
    state_d    = state_q;
    rem_d      = rem_q;
    ctx_d      = ctx_q;
    addr_d     = addr_q;
    disc_d     = disc_q;
    rem_en     = 1'b0;
    ctx_en     = 1'b0;
    addr_en    = 1'b0;
    disc_en    = 1'b0;
    fifo_pop   = 1'b0;
    bus_req    = 1'b0;
    wr_valid   = 1'b0;
    done_valid = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          rem_en   = 1'b1;
          rem_d    = hdr_words;
          ctx_en   = 1'b1;
          ctx_d    = hit_idx;
          if (hit_any) begin
            state_d = ST_REQ;
          end else if (hdr_words == '0) begin
            disc_en = 1'b1;
            disc_d  = disc_q + CNT_W'(1);
          end else begin
            state_d = ST_DRAIN;
          end
        end
      end
      ST_REQ: begin
        bus_req = 1'b1;
        if (bus_gnt) state_d = ST_DESC;
      end
      ST_DESC: begin
        bus_req = 1'b1;
        if (desc_valid) begin
          addr_en = 1'b1;
          addr_d  = desc_base;
          if (rem_q == '0) begin
            done_valid = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            state_d = ST_COPY;
          end
        end
      end
      ST_COPY: begin
        bus_req = 1'b1;
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          wr_valid = 1'b1;
          addr_en  = 1'b1;
          addr_d   = addr_q + ADDR_W'(1);
          rem_en   = 1'b1;
          rem_d    = rem_q - WORDS_W'(1);
          if (rem_q == WORDS_W'(1)) begin
            done_valid = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_DRAIN: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          rem_en   = 1'b1;
          rem_d    = rem_q - WORDS_W'(1);
          if (rem_q == WORDS_W'(1)) begin
            disc_en = 1'b1;
            disc_d  = disc_q + CNT_W'(1);
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      ctx_q   <= '0;
      addr_q  <= '0;
      disc_q  <= '0;
    end else begin
      state_q <= state_d;
      if (rem_en)  rem_q  <= rem_d;
      if (ctx_en)  ctx_q  <= ctx_d;
      if (addr_en) addr_q <= addr_d;
      if (disc_en) disc_q <= disc_d;
    end
  end

  assign wr_addr       = addr_q;
  assign wr_data       = fifo_rdata;
  assign done_ctx      = ctx_q;
  assign discard_count = disc_q;

  // R2: never pop a FIFO that shows nothing
  a_r2_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  // R8: payload beats only while the bus is held
  a_r8_write_holds_bus: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> bus_req);
  // R9: back-to-back beats step the word address by one
  a_r9_addr_increments: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));
  // R10: completion reported only with a final beat or a zero-length descriptor
  a_r10_done_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (wr_valid || desc_valid));
  // R11: the drop counter moves by at most one per cycle
  a_r11_discard_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_count != $past(discard_count)) |->
      (discard_count == $past(discard_count) + CNT_W'(1)));
endmodule

// File: rtl/iso_rx_dispatch.sv
module iso_rx_dispatch
  import iso_rx_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fifo_empty,
  input  logic [WORD_W-1:0]            fifo_rdata,
  output logic                         fifo_pop,
  input  logic [NUM_CTX-1:0]           ctx_enable,
  input  logic [NUM_CTX-1:0]           ctx_multi,
  input  logic [NUM_CTX*CHAN_W-1:0]    ctx_channel,
  input  logic [NUM_CTX*NUM_CHAN-1:0]  ctx_chan_mask,
  input  logic [NUM_CTX*NUM_TAG-1:0]   ctx_tag_mask,
  output logic                         bus_req,
  input  logic                         bus_gnt,
  input  logic                         desc_valid,
  input  logic [ADDR_W-1:0]            desc_base,
  output logic                         wr_valid,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [WORD_W-1:0]            wr_data,
  output logic                         done_valid,
  output logic [IDX_W-1:0]             done_ctx,
  output logic [CNT_W-1:0]             discard_count
);
  logic [CHAN_W-1:0]  pkt_chan;
  logic [TAG_W-1:0]   pkt_tag;
  logic [NUM_CTX-1:0] ctx_hit;
  logic [NUM_CTX-1:0] ctx_grant;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;

  assign pkt_chan = fifo_rdata[CHAN_LSB +: CHAN_W];
  assign pkt_tag  = fifo_rdata[TAG_LSB +: TAG_W];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    iso_rx_ctx_match u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (ctx_enable[g]),
      .multi     (ctx_multi[g]),
      .cfg_chan  (ctx_channel[g*CHAN_W +: CHAN_W]),
      .chan_mask (ctx_chan_mask[g*NUM_CHAN +: NUM_CHAN]),
      .tag_mask  (ctx_tag_mask[g*NUM_TAG +: NUM_TAG]),
      .pkt_chan  (pkt_chan),
      .pkt_tag   (pkt_tag),
      .hit       (ctx_hit[g])
    );
  end

  iso_rx_prio #(.N(NUM_CTX)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (ctx_hit),
    .any   (hit_any),
    .idx   (hit_idx),
    .grant (ctx_grant)
  );

  iso_rx_seq #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_empty    (fifo_empty),
    .fifo_rdata    (fifo_rdata),
    .fifo_pop      (fifo_pop),
    .hit_any       (hit_any),
    .hit_idx       (hit_idx),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .desc_valid    (desc_valid),
    .desc_base     (desc_base),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .done_valid    (done_valid),
    .done_ctx      (done_ctx),
    .discard_count (discard_count)
  );

  // R7: the winning grant agrees with the index handed to the sequencer
  a_r7_winner_hits: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (ctx_grant[hit_idx] && ctx_hit[hit_idx]));
endmodule

// File: tb/iso_rx_dispatch_bench.sv
module iso_rx_dispatch_bench;
  localparam int NC = 8;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  rd_ptr, wr_ptr;
  logic [31:0] mem [0:255];
  logic        fifo_empty, fifo_pop;
  logic [31:0] fifo_rdata;
  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_rdata = mem[rd_ptr];

  logic [NC-1:0]    en_v, multi_v;
  logic [5:0]       chan_v  [NC];
  logic [63:0]      cmask_v [NC];
  logic [3:0]       tmask_v [NC];
  logic [NC*6-1:0]  ctx_channel;
  logic [NC*64-1:0] ctx_chan_mask;
  logic [NC*4-1:0]  ctx_tag_mask;
  always_comb begin
    for (int i = 0; i < NC; i++) begin
      ctx_channel[i*6 +: 6]    = chan_v[i];
      ctx_chan_mask[i*64 +: 64] = cmask_v[i];
      ctx_tag_mask[i*4 +: 4]   = tmask_v[i];
    end
  end

  logic          bus_req, bus_gnt, desc_valid, wr_valid, done_valid;
  logic [AW-1:0] desc_base, wr_addr;
  logic [31:0]   wr_data;
  logic [2:0]    done_ctx;
  logic [CW-1:0] discard_count;

  iso_rx_dispatch #(.NUM_CTX(NC), .ADDR_W(AW), .CNT_W(CW)) u_iso_rx_dispatch (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .fifo_pop(fifo_pop), .ctx_enable(en_v), .ctx_multi(multi_v),
    .ctx_channel(ctx_channel), .ctx_chan_mask(ctx_chan_mask), .ctx_tag_mask(ctx_tag_mask),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .desc_valid(desc_valid), .desc_base(desc_base),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .done_valid(done_valid),
    .done_ctx(done_ctx), .discard_count(discard_count));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ptr <= '0;
    else if (fifo_pop) rd_ptr <= rd_ptr + 8'd1;
  end

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // observation at the falling edge
  int          nb, ndone, early_pop;
  bit          saw_req, done_beat;
  logic [2:0]  last_ctx;
  logic [31:0] b_addr [0:63];
  logic [31:0] b_data [0:63];
  bit          desc_wait;
  logic [31:0] next_base;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && nb < 64) begin b_addr[nb] = wr_addr; b_data[nb] = wr_data; end
      if (wr_valid) nb = nb + 1;
      if (done_valid) begin ndone = ndone + 1; last_ctx = done_ctx; done_beat = wr_valid; end
      if (bus_req) saw_req = 1;
      if (fifo_pop && desc_wait) early_pop = early_pop + 1;
    end
  end

  // bus responder: grant, then descriptor
  initial begin
    bus_gnt = 0; desc_valid = 0; desc_base = '0; desc_wait = 0;
    forever begin
      @(negedge clk);
      if (bus_req) begin
        desc_wait = 1;
        repeat (2) @(posedge clk);
        #1 bus_gnt = 1;
        @(posedge clk);
        #1 bus_gnt = 0;
        repeat (2) @(posedge clk);
        #1 desc_valid = 1; desc_base = next_base; desc_wait = 0;
        @(posedge clk);
        #1 desc_valid = 0;
        @(negedge clk);
        while (bus_req) @(negedge clk);
      end
    end
  end

  task automatic chk(input string rq, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int model_ctx(input int ch, input int tg);
    for (int i = 0; i < NC; i++)
      if (en_v[i] && tmask_v[i][tg] && (multi_v[i] ? cmask_v[i][ch] : (chan_v[i] == 6'(ch))))
        return i;
    return -1;
  endfunction

  task automatic push(input logic [31:0] w);
    mem[wr_ptr] = w;
    wr_ptr = wr_ptr + 8'd1;
  endtask

  int pkt_id = 0;

  task automatic run_packet(input string rq, input int ch, input int tg, input int len,
                            input logic [31:0] base, input int gap);
    int exp, nw, nd0;
    logic [CW-1:0] d0;
    exp = model_ctx(ch, tg);
    nw = (len + 3) / 4;
    pkt_id++;
    @(posedge clk); #1;
    nb = 0; nd0 = ndone; d0 = discard_count; saw_req = 0; early_pop = 0;
    done_beat = 0; next_base = base;
    push({16'(len), 2'(tg), 6'(ch), 4'hA, 4'h0});
    for (int i = 0; i < nw; i++) begin
      if (gap > 0 && i == nw / 2 && i > 0) begin
        repeat (gap) @(posedge clk);
        #1;
      end
      push(32'hC0DE0000 | (32'(pkt_id) << 8) | 32'(i));
    end
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (exp >= 0 && ndone != nd0) break;
      if (exp < 0 && discard_count != d0) break;
    end
    repeat (4) @(negedge clk);
    if (exp >= 0) begin
      chk({rq, " done count"}, ndone == nd0 + 1, 64'(ndone - nd0), 64'd1);
      chk({rq, " R10 done_ctx"}, last_ctx == 3'(exp), 64'(last_ctx), 64'(exp));
      chk({rq, " R9 beat count"}, nb == nw, 64'(nb), 64'(nw));
      for (int i = 0; i < nw && i < 64; i++) begin
        chk({rq, " R9 addr"}, b_addr[i] == base + 32'(i), 64'(b_addr[i]), 64'(base + 32'(i)));
        chk({rq, " R9 data"}, b_data[i] == (32'hC0DE0000 | (32'(pkt_id) << 8) | 32'(i)),
            64'(b_data[i]), 64'(32'hC0DE0000 | (32'(pkt_id) << 8) | 32'(i)));
      end
      chk({rq, " R8 no early pop"}, early_pop == 0, 64'(early_pop), 64'd0);
      chk({rq, " R10 done with last beat"}, done_beat == (nw > 0), 64'(done_beat), 64'(nw > 0));
      chk({rq, " discard unchanged"}, discard_count == d0, 64'(discard_count), 64'(d0));
    end else begin
      chk({rq, " R11 discard step"}, discard_count == d0 + 1, 64'(discard_count), 64'(d0 + 1));
      chk({rq, " R11 no beats"}, nb == 0, 64'(nb), 64'd0);
      chk({rq, " R11 no bus_req"}, saw_req == 0, 64'(saw_req), 64'd0);
      chk({rq, " R11 no done"}, ndone == nd0, 64'(ndone), 64'(nd0));
    end
    chk({rq, " fifo drained"}, rd_ptr == wr_ptr, 64'(rd_ptr), 64'(wr_ptr));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 fifo_pop", fifo_pop == 0, 64'(fifo_pop), 0);
    chk("R1 bus_req", bus_req == 0, 64'(bus_req), 0);
    chk("R1 wr_valid", wr_valid == 0, 64'(wr_valid), 0);
    chk("R1 done_valid", done_valid == 0, 64'(done_valid), 0);
    chk("R1 discard_count", discard_count == 0, 64'(discard_count), 0);
  endtask

  task automatic t_header_pop_immediate;
    logic [CW-1:0] d0;
    @(posedge clk); #1;
    d0 = discard_count;
    push({16'd0, 2'd0, 6'd2, 8'h00});
    @(negedge clk);
    chk("R2 header popped at once", fifo_pop == 1, 64'(fifo_pop), 1);
    @(negedge clk);
    chk("R12 zero-length discard next cycle", discard_count == d0 + 1, 64'(discard_count), 64'(d0 + 1));
  endtask

  task automatic t_single;       run_packet("R3 single channel ctx3", 10, 1, 13, 32'h1000, 0); endtask
  task automatic t_multi;        run_packet("R4 multichannel ctx5 ch63", 63, 3, 8, 32'h2000, 0); endtask
  task automatic t_tag;          run_packet("R5 tag filtered", 10, 2, 12, 32'h0, 0); endtask
  task automatic t_prio;
    run_packet("R7 ctx1 over ctx5", 20, 0, 4, 32'h3000, 0);
    run_packet("R7 ctx5 over ctx6", 40, 2, 16, 32'h4000, 0);
  endtask
  task automatic t_disabled;
    @(posedge clk); #1 en_v[3] = 0;
    run_packet("R6 disabled ctx", 10, 0, 8, 32'h0, 0);
    @(posedge clk); #1 en_v[3] = 1;
  endtask
  task automatic t_zero;         run_packet("R12 zero-length accept", 20, 1, 0, 32'h5000, 0); endtask
  task automatic t_one_word;     run_packet("R10 one word", 41, 0, 3, 32'h6000, 0); endtask
  task automatic t_gap;          run_packet("R9 stalled payload", 10, 0, 24, 32'h7000, 6); endtask
  task automatic t_drain_long;   run_packet("R11 long discard", 5, 0, 40, 32'h0, 3); endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wr_ptr = '0; nb = 0; ndone = 0; early_pop = 0; saw_req = 0; done_beat = 0;
    last_ctx = '0; next_base = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    en_v = '0; multi_v = '0;
    for (int i = 0; i < NC; i++) begin chan_v[i] = '0; cmask_v[i] = '0; tmask_v[i] = 4'hF; end
    chan_v[0] = 6'd10;
    en_v[1] = 1; chan_v[1] = 6'd20;
    en_v[3] = 1; chan_v[3] = 6'd10; tmask_v[3] = 4'b0011;
    en_v[5] = 1; multi_v[5] = 1; chan_v[5] = 6'd7;
    cmask_v[5] = (64'd1 << 40) | (64'd1 << 41) | (64'd1 << 63) | (64'd1 << 20);
    en_v[6] = 1; multi_v[6] = 1; cmask_v[6] = (64'd1 << 40);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_header_pop_immediate();
    t_single();
    t_multi();
    t_tag();
    t_prio();
    t_disabled();
    t_zero();
    t_one_word();
    t_gap();
    t_drain_long();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule